// File: doc/BRIEF.md
# Serial Status LED Frame Driver

This block collects per-port fault and traffic flags, global fault flags, and three traffic-rate percentages. It sends them to an external chain of shift registers that drives a bank of LEDs. Each refresh period it emits one burst of sixteen clock pulses on a gated LED clock. On every pulse it presents one bit on each of three active-low data lines, so that one burst fills up to forty-eight LEDs. Two utilization percentages (one for each link speed) and one collision percentage are turned into eight-step bar graphs with non-linear steps.

After reset the block runs a lamp test before it shows live status. Every LED goes on, then off, then on, then off, and each phase lasts a fixed number of clock cycles. All timing comes from counters on the system clock. The refresh period, the LED clock rate and the lamp-test phase length are parameters, so simulation can use short values. The contents of a frame are captured in a single cycle just before its burst. Input changes during a burst therefore never tear a frame.

Top module: `led_frame_drv`

## Requirements
- R1: One refresh period is FRAME_CYC clock cycles. The first period begins at the first clock edge after reset is released. Each period starts with a burst of exactly 16 LED clock pulses. After the burst, and until the next period, the LED clock is low and all three data lines are high.
- R2: One LED clock period is 2^(CK_HALF_LOG2+1) system cycles: a low half, then a high half. Bit slot b (b = 0..15) starts at period cycle b·2^(CK_HALF_LOG2+1). The data lines change only while the LED clock is low, so they are stable while it is high.
- R3: The data lines are active low. A lit LED is sent as 0 and an unlit LED as 1.
- R4: Line 0 sends, in slot order: jabber flags for ports 4,3,2,1,0; then partition flags for ports 4..0; then activity flags for ports 4..0; then one unlit bit in slot 15.
- R5: Line 1 sends, in slot order: an unlit bit; global partition; RAM-test-fail; the collision bar from step 7 down to step 0 (slots 3..10); three unlit bits (slots 11..13); the 10 Mb/s collision flag (slot 14); the 100 Mb/s collision flag (slot 15).
- R6: Line 2 sends the 10 Mb/s utilization bar from step 7 down to step 0 (slots 0..7), then the 100 Mb/s utilization bar from step 7 down to step 0 (slots 8..15).
- R7: Utilization bar step n is lit when the percentage is at least 1, 5, 10, 15, 30, 40, 60 or 80, for n = 0 to 7 in that order.
- R8: Collision bar step n is lit when the collision percentage is at least 1, 2, 5, 10, 15, 20, 30 or 60, for n = 0 to 7 in that order.
- R9: From reset release the lamp test runs four phases of BLINK_CYC cycles each: all lit, all unlit, all lit, all unlit. Live status follows. A frame shows the phase in effect on the last cycle of the period before it, and the first frame shows all lit. Status inputs have no effect on a lamp-test frame. While reset is held, the LED clock is low and all data lines are low.
- R10: Status and rate inputs are sampled only on the last cycle of each period. Changes made during a burst do not alter the frame being sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| jab_i | input | 5 | Per-port jabber flags, bit p = port p |
| part_i | input | 5 | Per-port partition flags |
| act_i | input | 5 | Per-port activity flags |
| gpart_i | input | 1 | Global partition flag |
| ram_fail_i | input | 1 | Bridge RAM self-test failure flag |
| col10_i | input | 1 | 10 Mb/s collision flag |
| col100_i | input | 1 | 100 Mb/s collision flag |
| util10_i | input | 7 | 10 Mb/s utilization, percent 0..100 |
| util100_i | input | 7 | 100 Mb/s utilization, percent 0..100 |
| coll_pct_i | input | 7 | Collision rate, percent 0..100 |
| led_ck_o | output | 1 | Gated LED shift clock |
| led_o | output | 3 | Serial LED data lines, active low |

## Verification
The embedded properties assume rate inputs never exceed 100 and flags are ordinary two-state levels. They also assume FRAME_CYC exceeds the burst length and BLINK_CYC is at least one. The bench uses a short period, a two-cycle LED clock half and a lamp-test phase that is not a multiple of the period, so that phase boundaries fall between frames. It changes its inputs only just after a burst has started and percentages stay inside 0..100. The percentage sequence steps across every threshold from just below to exactly on it.

// File: rtl/led_pkg.sv
package led_pkg;
    localparam int NPORT      = 5;
    localparam int BAR_W      = 8;
    localparam int FRAME_BITS = 16;
    localparam int NLINE      = 3;
    localparam int PCT_W      = 7;

    typedef logic [FRAME_BITS-1:0] word_t;
    typedef logic [BAR_W-1:0][PCT_W-1:0] thr_t;

    // step n lights at thresholds[n]
    localparam thr_t UTIL_THR = {7'd80, 7'd60, 7'd40, 7'd30, 7'd15, 7'd10, 7'd5, 7'd1};
    localparam thr_t COLL_THR = {7'd60, 7'd30, 7'd20, 7'd15, 7'd10, 7'd5, 7'd2, 7'd1};

    typedef enum logic [2:0] {
        PH_ON1  = 3'd0,
        PH_OFF1 = 3'd1,
        PH_ON2  = 3'd2,
        PH_OFF2 = 3'd3,
        PH_RUN  = 3'd4
    } phase_e;
endpackage

// File: rtl/led_therm_bar.sv
module led_therm_bar
    import led_pkg::*;
#(
    parameter thr_t THR = UTIL_THR
) (
    input  logic [PCT_W-1:0] pct_i,
    output logic [BAR_W-1:0] bar_o
);
    for (genvar n = 0; n < BAR_W; n++) begin : g_step
        assign bar_o[n] = (pct_i >= THR[n]);
    end
endmodule

// File: rtl/led_frame_pack.sv
module led_frame_pack
    import led_pkg::*;
(
    input  phase_e               phase_i,
    input  logic [NPORT-1:0]     jab_i,
    input  logic [NPORT-1:0]     part_i,
    input  logic [NPORT-1:0]     act_i,
    input  logic                 gpart_i,
    input  logic                 ram_fail_i,
    input  logic                 col10_i,
    input  logic                 col100_i,
    input  logic [BAR_W-1:0]     u10_bar_i,
    input  logic [BAR_W-1:0]     u100_bar_i,
    input  logic [BAR_W-1:0]     coll_bar_i,
    output word_t [NLINE-1:0]    lit_o
);
    // bit FRAME_BITS-1 goes out in slot 0; a 1 means the LED is lit
    always_comb begin
        unique case (phase_i)
            PH_ON1, PH_ON2:   lit_o = {NLINE{{FRAME_BITS{1'b1}}}};
            PH_OFF1, PH_OFF2: lit_o = '0;
            default: begin
                lit_o[0] = {jab_i, part_i, act_i, 1'b0};
                lit_o[1] = {1'b0, gpart_i, ram_fail_i, coll_bar_i, 3'b000, col10_i, col100_i};
                lit_o[2] = {u10_bar_i, u100_bar_i};
            end
        endcase
    end
endmodule

// File: rtl/led_frame_drv.sv
module led_frame_drv
    import led_pkg::*;
#(
    parameter int CK_HALF_LOG2 = 2,
    parameter int FRAME_CYC    = 5_000_000,
    parameter int BLINK_CYC    = 16_760_000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NPORT-1:0]     jab_i,
    input  logic [NPORT-1:0]     part_i,
    input  logic [NPORT-1:0]     act_i,
    input  logic                 gpart_i,
    input  logic                 ram_fail_i,
    input  logic                 col10_i,
    input  logic                 col100_i,
    input  logic [PCT_W-1:0]     util10_i,
    input  logic [PCT_W-1:0]     util100_i,
    input  logic [PCT_W-1:0]     coll_pct_i,
    output logic                 led_ck_o,
    output logic [NLINE-1:0]     led_o
);
    localparam int BURST_CYC = 2 ** (CK_HALF_LOG2 + 5);
    localparam int CNT_W     = $clog2(FRAME_CYC);
    localparam int BLK_W     = (BLINK_CYC > 1) ? $clog2(BLINK_CYC) : 1;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [BLK_W-1:0]  blk;
        phase_e            phase;
        word_t [NLINE-1:0] lit;
    } st_t;

    st_t st_d, st_q;

    logic [BAR_W-1:0]  u10_bar, u100_bar, coll_bar;
    word_t [NLINE-1:0] lit_new;
    logic              frame_end, in_burst;
    logic [3:0]        slot;

    led_therm_bar #(.THR(UTIL_THR)) u_bar_u10  (.pct_i(util10_i),   .bar_o(u10_bar));
    led_therm_bar #(.THR(UTIL_THR)) u_bar_u100 (.pct_i(util100_i),  .bar_o(u100_bar));
    led_therm_bar #(.THR(COLL_THR)) u_bar_coll (.pct_i(coll_pct_i), .bar_o(coll_bar));

    led_frame_pack u_pack (
        .phase_i    (st_q.phase),
        .jab_i      (jab_i),
        .part_i     (part_i),
        .act_i      (act_i),
        .gpart_i    (gpart_i),
        .ram_fail_i (ram_fail_i),
        .col10_i    (col10_i),
        .col100_i   (col100_i),
        .u10_bar_i  (u10_bar),
        .u100_bar_i (u100_bar),
        .coll_bar_i (coll_bar),
        .lit_o      (lit_new)
    );

    assign frame_end = (st_q.cnt == CNT_W'(FRAME_CYC - 1));
    assign in_burst  = (st_q.cnt < CNT_W'(BURST_CYC));
    assign slot      = st_q.cnt[CK_HALF_LOG2+4 -: 4];

    always_comb begin
        st_d     = st_q;
        st_d.cnt = frame_end ? '0 : st_q.cnt + 1'b1;
        if (st_q.phase != PH_RUN) begin
            if (st_q.blk == BLK_W'(BLINK_CYC - 1)) begin
                st_d.blk   = '0;
                st_d.phase = phase_e'(st_q.phase + 3'd1);
            end else begin
                st_d.blk = st_q.blk + 1'b1;
            end
        end
        if (frame_end) begin
            st_d.lit = lit_new;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt   <= '0;
            st_q.blk   <= '0;
            st_q.phase <= PH_ON1;
            st_q.lit   <= {NLINE{{FRAME_BITS{1'b1}}}};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        led_ck_o = in_burst & st_q.cnt[CK_HALF_LOG2];
        for (int i = 0; i < NLINE; i++) begin
            led_o[i] = in_burst ? ~st_q.lit[i][4'd15 - slot] : 1'b1;
        end
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < CNT_W'(FRAME_CYC)); // R1
    AST_DATA_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        led_ck_o |-> $stable(led_o)); // R2
    AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> $stable(st_q.lit)); // R10
    AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_RUN) |=> (st_q.phase == PH_RUN)); // R9
    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase != PH_RUN) |=> (st_q.phase == $past(st_q.phase)) ||
                                   (st_q.phase == phase_e'($past(st_q.phase) + 3'd1))); // R9
    AST_UTIL_THERMO: assert property (@(posedge clk) disable iff (!rst_n)
        ((u10_bar >> 1) & ~u10_bar) == '0 && ((u100_bar >> 1) & ~u100_bar) == '0); // R7
    AST_COLL_THERMO: assert property (@(posedge clk) disable iff (!rst_n)
        ((coll_bar >> 1) & ~coll_bar) == '0); // R8
endmodule

// File: tb/led_frame_drv_tb.sv
`timescale 1ns/1ps
module led_frame_drv_tb;
    localparam int L  = 1;
    localparam int F  = 80;
    localparam int B  = 200;
    localparam int NF = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] jab, part, act;
    logic       gpart, ramf, c10, c100;
    logic [6:0] u10, u100, cpct;
    logic       led_ck;
    logic [2:0] led;

    int checks = 0;
    int errors = 0;
    int started = 0;
    int done = 0;

    typedef struct { logic [15:0] w0, w1, w2; bit blink; } exp_t;
    exp_t expq[$];

    always #2.5 clk = ~clk;

    led_frame_drv #(.CK_HALF_LOG2(L), .FRAME_CYC(F), .BLINK_CYC(B)) u_dut (
        .clk(clk), .rst_n(rst_n), .jab_i(jab), .part_i(part), .act_i(act),
        .gpart_i(gpart), .ram_fail_i(ramf), .col10_i(c10), .col100_i(c100),
        .util10_i(u10), .util100_i(u100), .coll_pct_i(cpct),
        .led_ck_o(led_ck), .led_o(led));

    function automatic int uthr(int n);
        case (n) 0: return 1; 1: return 5; 2: return 10; 3: return 15;
                 4: return 30; 5: return 40; 6: return 60; default: return 80; endcase
    endfunction
    function automatic int cthr(int n);
        case (n) 0: return 1; 1: return 2; 2: return 5; 3: return 10;
                 4: return 15; 5: return 20; 6: return 30; default: return 60; endcase
    endfunction
    function automatic logic [7:0] ubar(int p); // R7
        logic [7:0] b;
        for (int n = 0; n < 8; n++) b[n] = (p >= uthr(n));
        return b;
    endfunction
    function automatic logic [7:0] cbar(int p); // R8
        logic [7:0] b;
        for (int n = 0; n < 8; n++) b[n] = (p >= cthr(n));
        return b;
    endfunction
    function automatic int ulist(int i);
        case (i % 17) 0: return 0; 1: return 1; 2: return 4; 3: return 5; 4: return 9;
            5: return 10; 6: return 14; 7: return 15; 8: return 29; 9: return 30;
            10: return 39; 11: return 40; 12: return 59; 13: return 60; 14: return 79;
            15: return 80; default: return 100; endcase
    endfunction
    function automatic int clist(int i);
        case (i % 17) 0: return 0; 1: return 1; 2: return 2; 3: return 4; 4: return 5;
            5: return 9; 6: return 10; 7: return 14; 8: return 15; 9: return 19;
            10: return 20; 11: return 29; 12: return 30; 13: return 59; 14: return 60;
            15: return 99; default: return 100; endcase
    endfunction
    // R9: phase shown by frame k, from the period's last cycle
    function automatic int phase_of(int k);
        int p;
        if (k == 0) return 0;
        p = (k * F - 1) / B;
        return (p > 4) ? 4 : p;
    endfunction

    task automatic apply(int k);
        u10   = 7'(ulist(k));
        u100  = 7'(ulist(k + 6));
        cpct  = 7'(clist(k));
        jab   = 5'(k * 7 + 1);
        part  = 5'(k * 11 + 3);
        act   = ~5'(k * 5);
        gpart = k[0];
        ramf  = k[1];
        c10   = k[2];
        c100  = k[0] ^ k[3];
    endtask

    task automatic push_exp(int k);
        exp_t e;
        int   ph = phase_of(k);
        e.blink = (ph != 4);
        if (ph == 0 || ph == 2) begin
            e.w0 = '1; e.w1 = '1; e.w2 = '1;
        end else if (ph == 1 || ph == 3) begin
            e.w0 = '0; e.w1 = '0; e.w2 = '0;
        end else begin
            e.w0 = {jab, part, act, 1'b0};                                  // R4
            e.w1 = {1'b0, gpart, ramf, cbar(int'(cpct)), 3'b000, c10, c100}; // R5
            e.w2 = {ubar(int'(u10)), ubar(int'(u100))};                      // R6
        end
        expq.push_back(e);
    endtask

    task automatic check(bit ok, string tag, int act_v, int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act_v, exp_v);
        end
    endtask

    // monitor: samples on falling edges, away from the active edge
    logic        prev_ck = 1'b0;
    int          nbits = 0;
    int          gap = 0;
    logic [15:0] w[3];
    always @(negedge clk) begin
        if (rst_n) begin
            if (led_ck === 1'b1 && prev_ck === 1'b0) begin
                if (nbits == 0) started++;
                for (int i = 0; i < 3; i++) w[i] = {w[i][14:0], ~led[i]}; // R3 active low
                nbits++;
                if (nbits == 16) begin
                    exp_t e;
                    nbits = 0;
                    if (expq.size() == 0) begin
                        check(1'b0, "R1 unexpected burst", 0, 0);
                    end else begin
                        e = expq.pop_front();
                        check(w[0] == e.w0, e.blink ? "R9 line0" : "R4 R10 line0", int'(w[0]), int'(e.w0));
                        check(w[1] == e.w1, e.blink ? "R9 line1" : "R5 R8 line1", int'(w[1]), int'(e.w1));
                        check(w[2] == e.w2, e.blink ? "R9 line2" : "R6 R7 line2", int'(w[2]), int'(e.w2));
                    end
                    gap = 8;
                    done++;
                end
            end
            if (gap > 0) begin
                gap--;
                if (gap == 0)
                    check(led_ck == 1'b0 && led == 3'b111, "R1 R2 idle gap",
                          int'({led_ck, led}), 32'h7);
            end
            prev_ck = led_ck;
        end
    end

    initial begin
        apply(0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(led_ck == 1'b0 && led == 3'b000, "R9 reset state", int'({led_ck, led}), 0);
        rst_n = 1'b1;
        push_exp(0);
        for (int k = 1; k < NF; k++) begin
            apply(k);
            push_exp(k);
            wait (started >= k + 1); // R10: next change lands mid-burst
            @(negedge clk);
        end
        wait (done >= NF);
        repeat (12) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R1 watchdog actual %0d frames expected %0d", done, NF);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule